// File: doc/BRIEF.md
# Mode-Configurable Address/IO Port

This block controls eight bidirectional pins of a small microcontroller. A 3-bit operating-mode input decides, pin by pin, whether a pin carries a bit of the external address bus, serves as a general-purpose output driven from a data register, or stays an input. Software reaches four registers over a simple synchronous register bus with a 16-bit address. The registers are a write-only direction register, a read/write output data register, a read-only view of the synchronized pin levels, and a pull-up control register. For each pin the block drives an output value, an output enable and a pull-up enable, which go to the pad.

The block tells apart power-on reset, manual reset, hardware standby and software standby. The direction setting survives a manual reset and software standby, and hardware standby wipes it. In software standby a hold control picks whether pins working as address outputs freeze on their last value or release the line. The register bus is plain: it has no valid/ready handshake and no back-pressure. Every write strobe is taken in the cycle it appears. Every read strobe returns its data on the next clock edge.

Top module: `addr_io_port`

## Requirements
- R1: Writes land only at these 16-bit addresses: direction 0xFEBA, data 0xFF6A, pull-up control 0xFF71. A read strobe returns its data on `bus_rdata` after the next rising edge. Reads of data and pull-up return the stored value. A read of an unmapped address returns 0x00, and writes to it change no register.
- R2: A read of the direction address 0xFEBA always returns the fixed value 0xFF, whatever the direction register holds.
- R3: Power-on reset (`por_n` low) clears the direction, data and pull-up registers to 0x00. While `hw_stby` is high the same three registers are cleared and register writes are ignored.
- R4: A manual reset (`mrst_n` low) clears the data and pull-up registers and leaves the direction register unchanged. While `sw_stby` is high all three registers keep their contents and writes are ignored.
- R5: In modes 1, 4 and 5 every pin drives `addr_out` for its bit (`pin_oe` = 0xFF), whatever the direction bits hold.
- R6: In modes 2 and 6, a pin whose direction bit is 1 drives its `addr_out` bit. A pin whose direction bit is 0 is an input with its output enable low.
- R7: In modes 0, 3 and 7, a pin whose direction bit is 1 drives its data-register bit. A pin whose direction bit is 0 is an input.
- R8: In software standby with `addr_hold` = 1, pins acting as address outputs keep driving the `addr_out` value sampled on the last edge before standby. With `addr_hold` = 0 those pins release their output enable. General-purpose outputs keep driving their data bit in software standby.
- R9: While `hw_stby` is high, every `pin_oe` bit is 0.
- R10: `pin_pu[i]` is 1 exactly when pull-up bit i is 1 and the pin is configured as an input in the current mode. It is never 1 while the pin's output enable is 1.
- R11: Pin levels reach the pin-state register at 0xFF5A through a two-flop synchronizer. A read issued on the same edge as a pin change returns the old level. A read issued two edges after the change returns the new level. `pin_out` is 0 for every pin whose output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| addr_hold | input | 1 | 1: address pins hold their value in software standby; 0: they float |
| op_mode | input | 3 | Operating mode |
| bus_addr | input | 16 | Register bus address (lower 16 bits) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, valid the edge after `bus_rd` |
| addr_out | input | 8 | Address bus bits from the bus controller |
| pin_in | input | 8 | Levels sampled at the pads |
| pin_out | output | 8 | Value driven to each pad |
| pin_oe | output | 8 | Output enable for each pad |
| pin_pu | output | 8 | Pull-up enable for each pad |

## Verification
The assertions assume that the standby and reset inputs, the mode and the bus strobes change only between clock edges, away from the rising edge. They also assume the mode is not changed in the middle of a software standby whose held address value is being checked. The stimulus drives every input at the falling edge. It changes the mode and register contents freely only outside standby. It enters software standby only after settling `addr_out` and the mode for at least one edge.

// File: rtl/portio_pkg.sv
package portio_pkg;
  localparam int unsigned PIN_W  = 8;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned MODE_W = 3;

  localparam logic [ADDR_W-1:0] A_DIR  = 16'hFEBA;
  localparam logic [ADDR_W-1:0] A_DATA = 16'hFF6A;
  localparam logic [ADDR_W-1:0] A_PINS = 16'hFF5A;
  localparam logic [ADDR_W-1:0] A_PULL = 16'hFF71;

  localparam logic [PIN_W-1:0] DIR_READ_VAL = '1;

  typedef enum logic [1:0] {
    PC_ALL_ADDR = 2'd0,
    PC_DIR_ADDR = 2'd1,
    PC_GPIO     = 2'd2
  } pin_class_e;

  function automatic pin_class_e mode_class(input logic [MODE_W-1:0] m);
    case (m)
      3'd1, 3'd4, 3'd5: mode_class = PC_ALL_ADDR;
      3'd2, 3'd6:       mode_class = PC_DIR_ADDR;
      default:          mode_class = PC_GPIO;
    endcase
  endfunction
endpackage

// File: rtl/portio_sync.sv
module portio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/portio_regs.sv
module portio_regs
  import portio_pkg::*;
#(
  parameter int unsigned W  = PIN_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          mrst_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  dat_q,
  output logic [W-1:0]  pull_q
);
  logic wr_ok;
  assign wr_ok = bus_wr && mrst_n && !hw_stby && !sw_stby;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dir_q <= '0;
    end else if (hw_stby) begin
      dir_q <= '0;
    end else if (wr_ok && bus_addr == A_DIR) begin
      dir_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dat_q  <= '0;
      pull_q <= '0;
    end else if (hw_stby || !mrst_n) begin
      dat_q  <= '0;
      pull_q <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_DATA) dat_q  <= bus_wdata;
      if (bus_addr == A_PULL) pull_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_DIR:   bus_rdata <= DIR_READ_VAL;
        A_DATA:  bus_rdata <= dat_q;
        A_PINS:  bus_rdata <= pin_sync;
        A_PULL:  bus_rdata <= pull_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_DIR_READ_FIXED: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rd && bus_addr == A_DIR) |=> bus_rdata == DIR_READ_VAL); // R2

  AST_HW_STBY_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |=> (dir_q == '0 && dat_q == '0 && pull_q == '0)); // R3

  AST_MRST_KEEPS_DIR: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && !hw_stby) |=> (dir_q == $past(dir_q) && dat_q == '0)); // R4

  AST_SW_STBY_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
    (sw_stby && mrst_n && !hw_stby) |=> (dir_q == $past(dir_q) && dat_q == $past(dat_q) && pull_q == $past(pull_q))); // R4
endmodule

// File: rtl/portio_pinmux.sv
module portio_pinmux
  import portio_pkg::*;
#(
  parameter int unsigned W  = PIN_W,
  parameter int unsigned MW = MODE_W
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic          addr_hold,
  input  logic [MW-1:0] op_mode,
  input  logic [W-1:0]  dir_q,
  input  logic [W-1:0]  dat_q,
  input  logic [W-1:0]  pull_q,
  input  logic [W-1:0]  addr_out,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_pu
);
  pin_class_e cls;
  logic [W-1:0] addr_keep;
  logic [W-1:0] is_addr, is_gpio;

  assign cls = mode_class(op_mode);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        addr_keep <= '0;
    else if (!sw_stby) addr_keep <= addr_out;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic addr_val, addr_en;
    assign is_addr[i] = (cls == PC_ALL_ADDR) || (cls == PC_DIR_ADDR && dir_q[i]);
    assign is_gpio[i] = (cls == PC_GPIO) && dir_q[i];
    assign addr_val   = sw_stby ? addr_keep[i] : addr_out[i];
    assign addr_en    = !sw_stby || addr_hold;

    always_comb begin
      pin_oe[i]  = 1'b0;
      pin_out[i] = 1'b0;
      if (!hw_stby) begin
        if (is_addr[i] && addr_en) begin
          pin_oe[i]  = 1'b1;
          pin_out[i] = addr_val;
        end else if (is_gpio[i]) begin
          pin_oe[i]  = 1'b1;
          pin_out[i] = dat_q[i];
        end
      end
      pin_pu[i] = pull_q[i] && !is_addr[i] && !is_gpio[i];
    end
  end

  AST_HW_STBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |-> pin_oe == '0); // R9

  AST_ALL_ADDR_MODE: assert property (@(posedge clk) disable iff (!por_n)
    (!hw_stby && !sw_stby && (op_mode == 3'd1 || op_mode == 3'd4 || op_mode == 3'd5))
      |-> (pin_oe == '1 && pin_out == addr_out)); // R5

  AST_SW_STBY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!hw_stby && sw_stby && $past(sw_stby) && addr_hold && $stable(op_mode) && $stable(dir_q))
      |-> $stable(pin_out & is_addr)); // R8

  AST_SW_STBY_FLOAT: assert property (@(posedge clk) disable iff (!por_n)
    (sw_stby && !addr_hold && op_mode == 3'd1) |-> pin_oe == '0); // R8

  AST_PU_NOT_DRIVING: assert property (@(posedge clk) disable iff (!por_n)
    (pin_pu & pin_oe) == '0); // R10

  AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!por_n)
    (pin_out & ~pin_oe) == '0); // R11
endmodule

// File: rtl/addr_io_port.sv
module addr_io_port
  import portio_pkg::*;
#(
  parameter int unsigned W          = PIN_W,
  parameter int unsigned AW         = ADDR_W,
  parameter int unsigned MW         = MODE_W,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          mrst_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic          addr_hold,
  input  logic [MW-1:0] op_mode,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  addr_out,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_pu
);
  logic [W-1:0] pin_sync, dir_q, dat_q, pull_q;

  portio_sync #(.WIDTH(W), .STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .por_n(por_n), .d(pin_in), .q(pin_sync)
  );

  portio_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .pin_sync(pin_sync),
    .bus_rdata(bus_rdata), .dir_q(dir_q), .dat_q(dat_q), .pull_q(pull_q)
  );

  portio_pinmux #(.W(W), .MW(MW)) u_mux (
    .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .addr_hold(addr_hold), .op_mode(op_mode), .dir_q(dir_q),
    .dat_q(dat_q), .pull_q(pull_q), .addr_out(addr_out),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  AST_WRITE_ACCEPTED: assert property (@(posedge clk) disable iff (!por_n)
    (bus_wr && mrst_n && !hw_stby && !sw_stby && bus_addr == A_DATA) |=> dat_q == $past(bus_wdata)); // R1
endmodule

// File: tb/tb_addr_io_port.sv
module tb_addr_io_port;
  logic        clk = 1'b0;
  logic        por_n, mrst_n, hw_stby, sw_stby, addr_hold;
  logic [2:0]  op_mode;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata, addr_out, pin_in, pin_out, pin_oe, pin_pu;
  int checks = 0, fails = 0;
  logic [7:0] m_dir, m_dat, m_pu;
  logic [7:0] rv;

  always #4 clk = ~clk;

  addr_io_port dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [7:0] f_addr_pins(input logic [2:0] m, input logic [7:0] dir);
    case (m)
      3'd1, 3'd4, 3'd5: return 8'hFF;
      3'd2, 3'd6:       return dir;
      default:          return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] f_gpio_pins(input logic [2:0] m, input logic [7:0] dir);
    return (f_addr_pins(m, dir) == 8'h00 && !(m == 3'd2 || m == 3'd6)) ? dir : 8'h00;
  endfunction

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    por_n = 0; mrst_n = 1; hw_stby = 0; sw_stby = 0; addr_hold = 0; op_mode = 3'd3;
    bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; addr_out = 0; pin_in = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    por_n = 1;
    // R3 reset state
    rd(16'hFF6A, rv); chk("R3 data after por", rv, 8'h00);
    rd(16'hFF71, rv); chk("R3 pull after por", rv, 8'h00);
    chk("R3 oe after por", pin_oe, 8'h00);
    // R1 decode
    wr(16'hFF6A, 8'h5A); rd(16'hFF6A, rv); chk("R1 data readback", rv, 8'h5A);
    wr(16'hFF71, 8'hC3); rd(16'hFF71, rv); chk("R1 pull readback", rv, 8'hC3);
    wr(16'h1234, 8'h77); rd(16'h1234, rv); chk("R1 unmapped read", rv, 8'h00);
    rd(16'hFF6A, rv); chk("R1 unmapped write no effect", rv, 8'h5A);
    // R2
    wr(16'hFEBA, 8'h0F); rd(16'hFEBA, rv); chk("R2 dir read fixed", rv, 8'hFF);
    @(negedge clk); chk("R7 gpio out via dir", pin_oe, 8'h0F);
    chk("R7 gpio data", pin_out, 8'h0A);
    chk("R10 pullup on inputs", pin_pu, 8'hC0);
    // R4 manual reset
    @(negedge clk); mrst_n = 0; @(negedge clk); mrst_n = 1;
    rd(16'hFF6A, rv); chk("R4 mrst clears data", rv, 8'h00);
    rd(16'hFF71, rv); chk("R4 mrst clears pull", rv, 8'h00);
    chk("R4 mrst keeps dir", pin_oe, 8'h0F);
    // R6 mode 2
    op_mode = 3'd2; addr_out = 8'hA5; @(negedge clk);
    chk("R6 mode2 oe", pin_oe, 8'h0F); chk("R6 mode2 out", pin_out, 8'h05);
    // R8 hold
    addr_hold = 1; sw_stby = 1; @(negedge clk); addr_out = 8'h3C; @(negedge clk);
    chk("R8 hold oe", pin_oe, 8'h0F); chk("R8 hold value", pin_out, 8'h05);
    wr(16'hFF6A, 8'hFF); rd(16'hFF6A, rv); chk("R4 sw stby blocks write", rv, 8'h00);
    addr_hold = 0; @(negedge clk); chk("R8 float", pin_oe, 8'h00);
    op_mode = 3'd7; @(negedge clk); chk("R8 gpio keeps driving", pin_oe, 8'h0F);
    sw_stby = 0; @(negedge clk);
    // R9 and R3 hw standby
    hw_stby = 1; @(negedge clk); chk("R9 hw oe", pin_oe, 8'h00);
    wr(16'hFF71, 8'hFF); hw_stby = 0;
    rd(16'hFF71, rv); chk("R3 hw blocks write", rv, 8'h00);
    @(negedge clk); chk("R3 hw clears dir", pin_oe, 8'h00);
    // R11 sync latency
    pin_in = 8'h96; rd(16'hFF5A, rv); chk("R11 early read old", rv, 8'h00);
    pin_in = 8'h69; @(negedge clk); @(negedge clk);
    rd(16'hFF5A, rv); chk("R11 read after 2 edges", rv, 8'h69);
    // random
    for (int k = 0; k < 300; k++) begin
      op_mode = 3'($urandom); m_dir = 8'($urandom); m_dat = 8'($urandom); m_pu = 8'($urandom);
      wr(16'hFEBA, m_dir); wr(16'hFF6A, m_dat); wr(16'hFF71, m_pu);
      addr_out = 8'($urandom); @(negedge clk);
      begin
        logic [7:0] ea, eg, eo;
        ea = f_addr_pins(op_mode, m_dir);
        eg = f_gpio_pins(op_mode, m_dir);
        eo = ea | eg;
        chk(op_mode inside {3'd1, 3'd4, 3'd5} ? "R5 oe" : (op_mode inside {3'd2, 3'd6} ? "R6 oe" : "R7 oe"), pin_oe, eo);
        chk("R11 out", pin_out, (ea & addr_out) | (eg & m_dat));
        chk("R10 pu", pin_pu, m_pu & ~eo);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule